// File: doc/BRIEF.md
# Weight-Stationary Systolic Tile Multiplier

This block multiplies a stream of activation rows by a weight tile held inside a square grid of multiply-accumulate cells. It computes Y[M,N] = X[M,K] · W[K,N] with K = N = the grid size. Each cell keeps one weight. Each clock it multiplies that weight by the activation passing through it from the left, adds the partial sum arriving from the cell above, and passes the sum down. The top row of cells starts from a partial sum of zero. Each activation row is skewed on entry, so grid row k sees its element k cycles late. Each column result is de-skewed on exit, so the bottom edge emits aligned output rows.

Weights go in first, one weight row per beat, through the top edge. They shift down the columns and then stay in place. After the N-th beat the block accepts activation rows on a valid/ready stream, one row per cycle with no bubbles. While the weights stay loaded, an M-row tile therefore leaves the bottom every M cycles. Operands are signed 8-bit and sums are 32-bit two's complement. Callers zero-pad short rows and tiles before they reach the block.

Top module: `ws_systolic_mm`

## Requirements
- R1: A weight beat is accepted when `wld_valid` and `wld_ready` are both high at a rising edge. Each accepted beat pushes the held weight rows one grid row down. After N beats, the first beat holds weight row N-1 and the last beat holds row 0. Column n of a beat sits at bits [n*8 +: 8].
- R2: `in_ready` is high only when N beats have completed since reset or since the last reload began, and `wld_valid` is low. A new weight beat drops it until N beats complete again. `in_valid` while `in_ready` is low is ignored and produces no output.
- R3: `wld_ready` is high exactly when no accepted activation row is still waiting to appear at the output, including the row currently shown.
- R4: For an accepted row x (element k at bits [k*8 +: 8], signed), the output element n at bits [n*32 +: 32] equals the sum over k of x[k]·W[k][n], in 32-bit two's complement.
- R5: A row accepted at rising edge t is shown with `out_valid` high during the cycle after edge t+2N-2, for exactly one cycle. `out_valid` is low in all other cycles.
- R6: Rows accepted on consecutive edges leave on consecutive cycles in arrival order. Gaps between accepted rows are kept unchanged at the output.
- R7: `out_last` is high on the M-th, 2M-th, ... output row counted since the last weight beat, and only when `out_valid` is high.
- R8: The most-negative operand value -128 is handled exactly in both activations and weights, including the all -128 case that gives 16384·N.
- R9: After reset, `out_valid`, `out_last` and `in_ready` are low, and `wld_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wld_valid | input | 1 | Weight row beat offered |
| wld_ready | output | 1 | Grid drained; weight beat can be taken |
| wld_row | input | N*DW | One weight row, column n at [n*DW +: DW] |
| in_valid | input | 1 | Activation row offered |
| in_ready | output | 1 | Weights complete; row can be taken |
| in_row | input | N*DW | Activation row, element k at [k*DW +: DW] |
| out_valid | output | 1 | Output row valid this cycle |
| out_last | output | 1 | Final row of an M-row output tile |
| out_row | output | N*AW | Result row, column n at [n*AW +: AW] |

## Verification
A wrong weight in one cell corrupts column n of every later output row. That error appears at the ports 2N-1 cycles after the first affected row is accepted. A broken skew or de-skew stage mixes products from neighbouring rows, so results differ as soon as two rows with different data are back to back. An error in the valid pipeline, the drain counter or the tile counter shifts `out_valid`, `wld_ready` or `out_last` by at least one cycle. The reference model compares all three every clock.

// File: rtl/ws_mm_pkg.sv
package ws_mm_pkg;
   localparam int DEF_GRID = 8;
   localparam int DEF_ROWS = 8;
   localparam int DEF_DW   = 8;
   localparam int DEF_AW   = 32;

   // edge registers between the accept edge and the last bottom-row sum
   function automatic int fill_depth(input int grid);
      return 2 * grid - 2;
   endfunction

   // extra output registers for bottom column col so all columns align
   function automatic int align_depth(input int grid, input int col);
      return grid - 1 - col;
   endfunction
endpackage

// File: rtl/ws_mm_delay.sv
module ws_mm_delay #(
   parameter int W     = 8,
   parameter int DEPTH = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (DEPTH == 0) begin : g_wire
         assign q = d;
      end else begin : g_regs
         logic [W-1:0] stage [DEPTH];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
            end else begin
               stage[0] <= d;
               for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
            end
         end
         assign q = stage[DEPTH-1];
      end
   endgenerate
endmodule

// File: rtl/ws_mm_pe.sv
module ws_mm_pe #(
   parameter int DW = 8,
   parameter int AW = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 w_shift,
   input  logic signed [DW-1:0] w_in,
   output logic signed [DW-1:0] w_q,
   input  logic signed [DW-1:0] x_in,
   output logic signed [DW-1:0] x_q,
   input  logic signed [AW-1:0] ps_in,
   output logic signed [AW-1:0] ps_q
);
   localparam int PW = 2 * DW;

   logic signed [PW-1:0] prod;
   logic signed [AW-1:0] prod_ext;

   assign prod     = x_in * w_q;
   assign prod_ext = {{(AW-PW){prod[PW-1]}}, prod};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         w_q  <= '0;
         x_q  <= '0;
         ps_q <= '0;
      end else begin
         if (w_shift) w_q <= w_in;
         x_q  <= x_in;
         ps_q <= ps_in + prod_ext;
      end
   end

   AST_WEIGHT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !w_shift |=> $stable(w_q)); // R1
endmodule

// File: rtl/ws_systolic_mm.sv
module ws_systolic_mm
   import ws_mm_pkg::*;
#(
   parameter int N  = DEF_GRID,
   parameter int M  = DEF_ROWS,
   parameter int DW = DEF_DW,
   parameter int AW = DEF_AW
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wld_valid,
   output logic            wld_ready,
   input  logic [N*DW-1:0] wld_row,
   input  logic            in_valid,
   output logic            in_ready,
   input  logic [N*DW-1:0] in_row,
   output logic            out_valid,
   output logic            out_last,
   output logic [N*AW-1:0] out_row
);
   localparam int FILL = fill_depth(N);
   localparam int VLEN = FILL + 1;
   localparam int WCW  = $clog2(N + 1);
   localparam int FCW  = $clog2(VLEN + 2);
   localparam int OCW  = (M > 1) ? $clog2(M) : 1;

   generate
      if (N < 2) begin : g_bad_grid
         $error("ws_systolic_mm: grid size must be at least 2");
      end
      if (M < 1) begin : g_bad_rows
         $error("ws_systolic_mm: tile row count must be at least 1");
      end
      if (AW < 2 * DW + $clog2(N)) begin : g_bad_acc
         $error("ws_systolic_mm: accumulator too narrow for the grid");
      end
   endgenerate

   // control
   logic           w_fire, x_fire, w_ok;
   logic [WCW-1:0] wcnt;
   logic [FCW-1:0] inflight;
   logic [VLEN-1:0] vpipe;
   logic [OCW-1:0] ocnt;

   assign w_ok      = (wcnt == WCW'(N));
   assign wld_ready = (inflight == '0);
   assign in_ready  = w_ok && !wld_valid;
   assign w_fire    = wld_valid && wld_ready;
   assign x_fire    = in_valid && in_ready;
   assign out_valid = vpipe[VLEN-1];
   assign out_last  = out_valid && (ocnt == OCW'(M - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wcnt     <= '0;
         inflight <= '0;
         vpipe    <= '0;
         ocnt     <= '0;
      end else begin
         if (w_fire) wcnt <= w_ok ? WCW'(1) : wcnt + WCW'(1);
         inflight <= inflight + FCW'(x_fire) - FCW'(out_valid);
         vpipe    <= {vpipe[VLEN-2:0], x_fire};
         if (w_fire)         ocnt <= '0;
         else if (out_valid) ocnt <= (ocnt == OCW'(M - 1)) ? '0 : ocnt + OCW'(1);
      end
   end

   // datapath
   logic signed [DW-1:0] xh [N][N+1];
   logic signed [DW-1:0] wv [N+1][N];
   logic signed [AW-1:0] ph [N+1][N];
   logic [N*DW-1:0]      x_gated;

   assign x_gated = x_fire ? in_row : '0;

   genvar k, n;
   generate
      for (k = 0; k < N; k++) begin : g_skew
         ws_mm_delay #(.W(DW), .DEPTH(k)) u_skew (
            .clk (clk), .rst_n (rst_n),
            .d   (x_gated[k*DW +: DW]),
            .q   (xh[k][0])
         );
      end
      for (n = 0; n < N; n++) begin : g_top
         assign wv[0][n] = wld_row[n*DW +: DW];
         assign ph[0][n] = '0;
      end
      for (k = 0; k < N; k++) begin : g_row
         for (n = 0; n < N; n++) begin : g_col
            ws_mm_pe #(.DW(DW), .AW(AW)) u_pe (
               .clk     (clk),
               .rst_n   (rst_n),
               .w_shift (w_fire),
               .w_in    (wv[k][n]),
               .w_q     (wv[k+1][n]),
               .x_in    (xh[k][n]),
               .x_q     (xh[k][n+1]),
               .ps_in   (ph[k][n]),
               .ps_q    (ph[k+1][n])
            );
         end
      end
      for (n = 0; n < N; n++) begin : g_align
         ws_mm_delay #(.W(AW), .DEPTH(align_depth(N, n))) u_align (
            .clk (clk), .rst_n (rst_n),
            .d   (ph[N][n]),
            .q   (out_row[n*AW +: AW])
         );
      end
   endgenerate

   AST_READY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_ready) |-> $past(wld_valid && wld_ready)); // R2
   AST_LOAD_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
      (wld_valid && wld_ready) |=> !out_valid); // R3
   AST_OUT_TRACKED: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (inflight != '0)); // R5
   AST_LAST_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid); // R7
endmodule

// File: tb/ws_systolic_mm_bench.sv
module ws_systolic_mm_bench;
   localparam int N  = 8;
   localparam int M  = 8;
   localparam int DW = 8;
   localparam int AW = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wld_valid = 1'b0;
   logic            wld_ready;
   logic [N*DW-1:0] wld_row = '0;
   logic            in_valid = 1'b0;
   logic            in_ready;
   logic [N*DW-1:0] in_row = '0;
   logic            out_valid, out_last;
   logic [N*AW-1:0] out_row;

   always #2.5 clk = ~clk;

   ws_systolic_mm #(.N(N), .M(M), .DW(DW), .AW(AW)) u_ws_systolic_mm (
      .clk(clk), .rst_n(rst_n),
      .wld_valid(wld_valid), .wld_ready(wld_ready), .wld_row(wld_row),
      .in_valid(in_valid), .in_ready(in_ready), .in_row(in_row),
      .out_valid(out_valid), .out_last(out_last), .out_row(out_row)
   );

   int checks = 0, errors = 0;
   int wm [N][N];
   int loaded = 0, ocnt = 0, cyc = 0;
   bit run = 0, done = 0;
   int due_q [$];
   logic [N*AW-1:0] y_q [$];

   task automatic chk(input bit ok, input string req, input logic [N*AW-1:0] act,
                      input logic [N*AW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   function automatic logic [N*AW-1:0] ref_row(input logic [N*DW-1:0] x);
      logic [N*AW-1:0] y;
      for (int c = 0; c < N; c++) begin
         int s = 0;
         for (int r = 0; r < N; r++) s += int'($signed(x[r*DW +: DW])) * wm[r][c];
         y[c*AW +: AW] = s;
      end
      return y;
   endfunction

   // reference model, compared every clock away from the edge
   always @(negedge clk) begin
      if (rst_n && run) begin
         bit exp_wr, exp_ir, exp_last;
         exp_wr = (due_q.size() == 0);
         exp_ir = (loaded == N) && !wld_valid;
         chk(wld_ready == exp_wr, "R3 wld_ready", N*AW'(wld_ready), N*AW'(exp_wr));
         chk(in_ready == exp_ir, "R2 in_ready", N*AW'(in_ready), N*AW'(exp_ir));
         if (due_q.size() > 0 && due_q[0] == cyc) begin
            exp_last = (ocnt % M) == (M - 1);
            chk(out_valid == 1'b1, "R5 out_valid", N*AW'(out_valid), 1);
            chk(out_row == y_q[0], "R4/R8 out_row", out_row, y_q[0]);
            chk(out_last == exp_last, "R7 out_last", N*AW'(out_last), N*AW'(exp_last));
            void'(due_q.pop_front());
            void'(y_q.pop_front());
            ocnt++;
         end else begin
            chk(out_valid == 1'b0, "R6 out_valid idle", N*AW'(out_valid), 0);
            chk(out_last == 1'b0, "R7 out_last idle", N*AW'(out_last), 0);
         end
         if (wld_valid && exp_wr) begin
            for (int r = N - 1; r > 0; r--)
               for (int c = 0; c < N; c++) wm[r][c] = wm[r-1][c];
            for (int c = 0; c < N; c++) wm[0][c] = int'($signed(wld_row[c*DW +: DW]));
            loaded = (loaded == N) ? 1 : loaded + 1;
            ocnt = 0;
         end
         if (in_valid && exp_ir) begin
            due_q.push_back(cyc + 2 * N - 1);
            y_q.push_back(ref_row(in_row));
         end
         cyc++;
      end
   end

   task automatic load_weights(input int mode);
      for (int b = 0; b < N; b++) begin
         logic [N*DW-1:0] row;
         for (int c = 0; c < N; c++) begin
            if (mode == 1)      row[c*DW +: DW] = 8'h80;
            else if (mode == 2) row[c*DW +: DW] = ((b + c) % 2 == 0) ? 8'h80 : 8'h7f;
            else                row[c*DW +: DW] = ((b * N + c) % 11 == 0) ? 8'h80 : 8'($urandom);
         end
         wld_valid = 1'b1;
         wld_row = row;
         do @(negedge clk); while (!wld_ready);
         @(posedge clk); #1;
         wld_valid = 1'b0;
      end
   endtask

   task automatic send_row(input int mode);
      logic [N*DW-1:0] x;
      for (int k = 0; k < N; k++) begin
         if (mode == 1)      x[k*DW +: DW] = 8'h80;
         else if (mode == 2) x[k*DW +: DW] = (k % 2 == 0) ? 8'h80 : 8'h7f;
         else                x[k*DW +: DW] = 8'($urandom);
      end
      in_valid = 1'b1;
      in_row = x;
      do @(negedge clk); while (!in_ready);
      @(posedge clk); #1;
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R9: reset state
      chk(out_valid == 0, "R9 out_valid", N*AW'(out_valid), 0);
      chk(out_last == 0, "R9 out_last", N*AW'(out_last), 0);
      chk(in_ready == 0, "R9 in_ready", N*AW'(in_ready), 0);
      chk(wld_ready == 1, "R9 wld_ready", N*AW'(wld_ready), 1);
      run = 1;
      @(posedge clk); #1;
      // R2: rows offered before weights are ignored
      in_valid = 1'b1;
      in_row = '1;
      repeat (4) @(posedge clk);
      #1 in_valid = 1'b0;
      // R1, R4: random weights, two back-to-back tiles (R6)
      load_weights(0);
      for (int r = 0; r < 2 * M; r++) send_row(0);
      // R6: rows with gaps
      for (int r = 0; r < 6; r++) begin
         send_row(0);
         repeat (r % 3) @(posedge clk);
         #1;
      end
      // R3: reload requested while rows are in flight, R8 extremes
      send_row(0);
      send_row(0);
      load_weights(1);
      for (int r = 0; r < M; r++) send_row(r % 2 == 0 ? 1 : 2);
      load_weights(2);
      for (int r = 0; r < M + 3; r++) send_row(r % 3);
      repeat (3 * N) @(posedge clk);
      done = 1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (50000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
         end
      join_any
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule